// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between an on-chip requester and an external byte-wide asynchronous static RAM with a 21-bit address. The requester sees a single-beat handshake. It raises `req` with an address, a direction flag and write data while `ready` is high, and for reads it receives the byte together with a one-clock `rvalid` pulse. On the memory side the block drives an active-low chip enable, an active-high chip enable, active-low output and write enables, the address, and a split data bus: `sram_dq_out`, a drive enable `sram_dq_oe`, and `sram_dq_in` coming back from the pad.

The controller is fully synchronous. Every minimum memory timing limit is a picosecond parameter. Each one is turned into a clock count by rounding up, with a floor of one cycle, from the clock period parameter `CLK_PS`. After reset the controller waits out a power-up lockout (100 µs by default) and only then offers `ready`.

Reads hold the chip selected with output enable low until the longer of the address-to-data and enable-to-data times has elapsed, sample the bus on the last of those cycles, then spend a release gap with output enable high. Writes keep output enable high throughout. They spend one setup cycle selected with both strobes high, pulse write enable low while driving the data, and end the write by raising write enable while the chip is still selected and the data is still driven.

Top module: `async_sram_ctl`

## Requirements
- R1: While reset is low and on the first cycle after it: `sram_ce1_n`=1, `sram_ce2`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `ready`=0, `rvalid`=0.
- R2: `ready` first reads 1 after exactly ceil(PWRUP_PS/CLK_PS) rising edges following reset release. Until then the memory is never selected (selected means `sram_ce1_n`=0 and `sram_ce2`=1).
- R3: A read (`req`=1, `rd_wr`=0 while `ready`=1) selects the memory with `sram_oe_n`=0 and `sram_we_n`=1 for max(ceil(T_AA/CLK), ceil(T_DOE/CLK)) cycles. The byte sampled on the last of those cycles appears on `rdata` with `rvalid`=1 for exactly one cycle.
- R4: A write (`rd_wr`=1) keeps `sram_oe_n`=1 throughout. It spends one cycle selected with both strobes high before `sram_we_n` falls. `sram_we_n` rises while the memory is still selected and `sram_dq_oe` is still 1, so the memory stores the byte.
- R5: `sram_dq_oe` is 1 only while `sram_oe_n`=1 and `sram_oe_n` was also 1 on the previous cycle. The controller never drives the bus while the memory does.
- R6: After a read, at least ceil(T_HZ/CLK)+1 cycles with `sram_oe_n`=1 pass before `sram_dq_oe` next rises.
- R7: `ready`=1 only while no access is in progress. A `req` seen while `ready`=0, including during the lockout, is ignored and leaves memory contents unchanged.
- R8: Address and write data are captured on acceptance. Later changes on `addr`/`wdata` do not affect the access, and `sram_addr` stays stable while the memory is selected.
- R9: `sram_we_n` stays low for max(ceil(T_PWE/CLK), ceil(T_SD/CLK), ceil(T_AW/CLK), ceil(T_WC/CLK)-2) cycles per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when `ready` is high |
| rd_wr | input | 1 | 1 = write, 0 = read |
| addr | input | 21 | Byte address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle and able to accept `req` |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | One-cycle pulse marking `rdata` valid |
| sram_addr | output | 21 | Memory address |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 8 | Data from the memory pads |

## Verification
In the idle cycle that follows a write, the controller's data release and the acceptance of a new read can happen together. The read then lowers output enable on the very next edge. The bench provokes this by queuing a read of the same address straight behind each write, and the reverse order too. A behavioural memory model flags any instant where both sides drive the bus, and the scoreboard requires the read to return the byte just written. The model also grades every write-ending edge for pulse width, data setup and address setup, and corrupts read data sampled before its access times are met.

// File: rtl/async_sram_ctl.sv
`timescale 1ns/1ps
module async_sram_ctl #(
  parameter int AW       = 21,
  parameter int DW       = 8,
  parameter int CLK_PS   = 10000,
  parameter int PWRUP_PS = 100000000,
  parameter int T_AA     = 10000,
  parameter int T_DOE    = 5000,
  parameter int T_PWE    = 7000,
  parameter int T_SD     = 5500,
  parameter int T_AW     = 7000,
  parameter int T_WC     = 10000,
  parameter int T_HZ     = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          rd_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  function automatic int cyc(input int t_ps);
    int n;
    n = (t_ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LOCK_CYC = cyc(PWRUP_PS);
  localparam int RD_CYC   = imax(cyc(T_AA), cyc(T_DOE));
  localparam int WP_CYC   = imax(imax(cyc(T_PWE), cyc(T_SD)), imax(cyc(T_AW), cyc(T_WC) - 2));
  localparam int HZ_CYC   = cyc(T_HZ);
  localparam int MAXC     = imax(imax(LOCK_CYC, RD_CYC), imax(WP_CYC, HZ_CYC));
  localparam int CW       = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_LOCK, S_IDLE, S_RD, S_RDHZ, S_WSU, S_WPW, S_WHD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          sel;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_LOCK;
      cnt    <= CW'(LOCK_CYC - 1);
      addr_q <= '0;
      wd_q   <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      unique case (st)
        S_LOCK: if (last) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: if (req) begin
          addr_q <= addr;
          wd_q   <= wdata;
          if (rd_wr) st <= S_WSU;
          else begin
            st  <= S_RD;
            cnt <= CW'(RD_CYC - 1);
          end
        end
        S_RD: if (last) begin
          rdata  <= sram_dq_in;
          rvalid <= 1'b1;
          st     <= S_RDHZ;
          cnt    <= CW'(HZ_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_RDHZ: if (last) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_WSU: begin
          st  <= S_WPW;
          cnt <= CW'(WP_CYC - 1);
        end
        S_WPW: if (last) st <= S_WHD; else cnt <= cnt - 1'b1;
        S_WHD: st <= S_IDLE;
        default: st <= S_LOCK;
      endcase
    end
  end

  assign sel         = (st == S_RD) || (st == S_WSU) || (st == S_WPW) || (st == S_WHD);
  assign ready       = (st == S_IDLE);
  assign sram_ce1_n  = ~sel;
  assign sram_ce2    = sel;
  assign sram_oe_n   = (st != S_RD);
  assign sram_we_n   = (st != S_WPW);
  assign sram_dq_oe  = (st == S_WPW) || (st == S_WHD);
  assign sram_dq_out = wd_q;
  assign sram_addr   = addr_q;
endmodule

// File: rtl/async_sram_ctl_chk.sv
`timescale 1ns/1ps
module async_sram_ctl_chk #(
  parameter int AW       = 21,
  parameter int CLK_PS   = 10000,
  parameter int PWRUP_PS = 100000000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rvalid,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce1_n,
  input logic          sram_ce2,
  input logic          sram_oe_n,
  input logic          sram_we_n,
  input logic          sram_dq_oe
);
  localparam int LOCK_CYC = ((PWRUP_PS + CLK_PS - 1) / CLK_PS < 1) ? 1 : (PWRUP_PS + CLK_PS - 1) / CLK_PS;
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] lk;
  logic          sel;
  assign sel = !sram_ce1_n && sram_ce2;

  always_ff @(posedge clk) begin
    if (!rst_n) lk <= '0;
    else if (lk != LW'(LOCK_CYC)) lk <= lk + 1'b1;
  end

  AST_LOCKOUT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (lk == LW'(LOCK_CYC))); // R2
  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R3
  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R4
  AST_WE_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sel && sram_dq_oe)); // R4
  AST_DRIVE_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n))); // R5
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!sel && sram_oe_n && sram_we_n && !sram_dq_oe)); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(sram_addr)); // R8
endmodule

bind async_sram_ctl async_sram_ctl_chk #(.AW(AW), .CLK_PS(CLK_PS), .PWRUP_PS(PWRUP_PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rvalid(rvalid), .sram_addr(sram_addr),
  .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n),
  .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_async_sram_ctl.sv
`timescale 1ns/1ps
module tb_async_sram_ctl;
  localparam int CLK_PERIOD = 4;
  localparam int LOCK_EXP = 25000;
  localparam int RD_EXP = 3;
  localparam int WP_EXP = 2;
  localparam int HZ_EXP = 2;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, rd_wr = 1'b0;
  logic [20:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready, rvalid, ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [7:0] rdata, dq_out, dq_in;
  logic [20:0] saddr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_sram_ctl #(.CLK_PS(CLK_PERIOD * 1000)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rd_wr(rd_wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .sram_addr(saddr),
    .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in));

  int checks = 0, fails = 0, viol = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]} ^ 8'hA5;
  endfunction

  // memory model
  logic [7:0] mem[int];
  logic sel, rd_cond, mdrv = 1'b0, in_wr = 1'b0;
  logic [7:0] mdata = '0;
  realtime t_addr = 0, t_oe = 0, t_wef = 0, t_dq = 0;
  assign sel = !ce1_n && ce2;
  assign rd_cond = sel && !oe_n && we_n;
  assign dq_in = dq_oe ? dq_out : (mdrv ? mdata : 8'h00);

  function automatic logic [7:0] mread(input logic [20:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_val(a);
  endfunction

  always @(rd_cond) begin
    if (rd_cond) mdrv = 1'b1;
    else begin
      #5;
      if (!rd_cond) mdrv = 1'b0;
    end
  end
  always @(mdrv or dq_oe) if (mdrv && dq_oe) viol++;
  always @(saddr) t_addr = $realtime;
  always @(negedge oe_n) t_oe = $realtime;
  always @(dq_out or posedge dq_oe) t_dq = $realtime;
  always @(negedge clk)
    mdata = (rd_cond && ($realtime - t_addr >= 10.0) && ($realtime - t_oe >= 5.0))
            ? mread(saddr) : ~mread(saddr);
  always @(posedge sel) if ($realtime < 100000.0) viol++;
  always @(negedge we_n) if (sel) begin in_wr = 1'b1; t_wef = $realtime; end
  always @(posedge we_n) if (in_wr) begin
    if (!sel || !dq_oe || ($realtime - t_wef < 7.0) || ($realtime - t_dq < 5.5) ||
        ($realtime - t_addr < 7.0)) viol++;
    mem[int'(saddr)] = dq_out;
    in_wr = 1'b0;
  end
  always @(posedge ce1_n or negedge ce2) if (in_wr && !we_n) viol++;

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] shadow[int];

  always @(negedge clk) if (rst_n && rvalid) begin
    if (exp_q.size() == 0) chk(1'b0, "R3 unexpected rvalid", 1, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rdata == e, "R3 read data", rdata, e);
    end
  end

  // strobe timing monitor
  int oe_lo = 0, we_lo = 0, since_oe = 1000;
  logic p_sel = 1'b0, p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  bit after_rd = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!oe_n) begin oe_lo++; since_oe = 0; after_rd = 1'b1; end
    else begin
      if (oe_lo > 0) chk(oe_lo == RD_EXP, "R3 oe low cycles", oe_lo, RD_EXP);
      oe_lo = 0;
      since_oe++;
    end
    if (!we_n) begin
      if (p_we) chk(p_sel && p_oe && oe_n, "R4 setup cycle before we low", {p_sel, p_oe}, 3);
      we_lo++;
    end else begin
      if (we_lo > 0) chk(we_lo == WP_EXP, "R9 we low cycles", we_lo, WP_EXP);
      we_lo = 0;
    end
    if (dq_oe && !p_dqoe && after_rd) begin
      chk(since_oe - 1 >= HZ_EXP + 1, "R6 turnaround gap", since_oe - 1, HZ_EXP + 1);
      after_rd = 1'b0;
    end
    p_sel = sel; p_we = we_n; p_oe = oe_n; p_dqoe = dq_oe;
  end

  task automatic op(input bit w, input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; rd_wr = w; addr = a; wdata = d;
    if (w) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a));
    @(negedge clk);
    req = 1'b0;
    addr = ~a; wdata = ~d;
    chk(!ready, "R7 ready low while busy", ready, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk({ce1_n, ce2, oe_n, we_n, dq_oe, ready, rvalid} == 7'b1011000, "R1 reset outputs",
        {ce1_n, ce2, oe_n, we_n, dq_oe, ready, rvalid}, 7'b1011000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce1_n, ce2, oe_n, we_n, dq_oe, ready} == 6'b101100, "R1 first cycle after reset",
        {ce1_n, ce2, oe_n, we_n, dq_oe, ready}, 6'b101100);
    n = 1;
    // R7: request during lockout is ignored
    repeat (50) @(negedge clk);
    n += 50;
    req = 1'b1; rd_wr = 1'b1; addr = 21'h01234; wdata = 8'h5A;
    repeat (5) @(negedge clk);
    n += 5;
    req = 1'b0;
    chk(ce1_n && !ce2 && !ready, "R7 no select during lockout", {ce1_n, ce2}, 2);
    while (!ready) begin @(negedge clk); n++; end
    chk(n == LOCK_EXP, "R2 lockout length", n, LOCK_EXP);
    op(1'b0, 21'h01234, 8'h00);
    // boundary addresses
    op(1'b1, 21'h000000, 8'h11);
    op(1'b1, 21'h1FFFFF, 8'hEE);
    op(1'b0, 21'h000000, 8'h00);
    op(1'b0, 21'h1FFFFF, 8'h00);
    // write then immediate read, read then immediate write
    for (int i = 0; i < 20; i++) begin
      logic [20:0] a;
      logic [7:0] d;
      a = 21'($urandom); d = 8'($urandom);
      op(1'b1, a, d);
      op(1'b0, a, 8'h00);
      op(1'b1, a ^ 21'h00F0F, ~d);
      op(1'b0, a ^ 21'h00F0F, 8'h00);
      op(1'b0, 21'($urandom), 8'h00);
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    chk(viol == 0, "R5 model timing/contention violations", viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule